// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host read and write an external asynchronous static RAM of 262,144 sixteen-bit words. The RAM has two byte lanes, each with its own active-low strobe. The host raises a request with an 18-bit word address, a read/write flag, 16 bits of write data and a 2-bit lane mask. The controller takes the request when its ready output is high. It then runs the RAM's control pins through a fixed sequence of phases and, for a read, returns the data with a one-cycle valid pulse.

All RAM timing minimums are parameters in nanoseconds, together with the clock period in picoseconds. Each phase length is the rounded-up number of clock cycles that covers its minimum. The RAM data bus is split into a separate input and output, plus a drive enable for the external tristate buffer. The controller turns the bus around so that the RAM and the host never drive it at the same time. All RAM control pins come straight from flip-flops, so they are free of glitches.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and afterwards while idle, `host_ready` is 1. `ram_sel_n`, `ram_read_n`, `ram_write_n` and both bits of `ram_lane_n` are 1, and `ram_dq_drive` and `host_rvalid` are 0.
- R2: A request is taken on a clock edge where `host_req` and `host_ready` are both 1. `host_ready` stays 0 from that edge until the access has finished.
- R3: A read (`host_we`=0) holds `ram_sel_n`=0, `ram_read_n`=0 and `ram_write_n`=1 for ACC cycles, where ACC = max(ceil(T_AA_NS/period), ceil(T_RC_NS/period)). `host_rvalid` is 1 for exactly one cycle, the (ACC+1)-th cycle after the accepting edge.
- R4: Mask bit 0 selects the low lane (data bits 7:0) and mask bit 1 the high lane (bits 15:8). A selected lane drives its `ram_lane_n` bit to 0 for the whole access. For a read, `host_rdata` carries the RAM data on selected lanes and zero on unselected lanes.
- R5: A write (`host_we`=1) holds `ram_write_n`=0 for PULSE cycles. PULSE = max(ceil(T_PWE_NS/p), ceil(T_DS_NS/p), ceil(T_AW_NS/p)-LEAD, ceil(T_WC_NS/p)-LEAD-1, 1). Only lanes whose mask bit is 1 are written, and a mask of 00 changes no stored data.
- R6: Before `ram_write_n` falls, the controller holds `ram_sel_n`=0 with address and lanes valid and `ram_read_n`=1 for LEAD = max(1, ceil(T_OEH_NS/period)) cycles.
- R7: `ram_dq_drive` is 1 in every cycle where `ram_write_n` is 0 and in the one cycle after it rises, and it is 0 in every other cycle. `ram_dq_drive` and a low `ram_read_n` never occur in the same cycle.
- R8: `ram_addr` and `ram_lane_n` do not change while `ram_sel_n` stays 0. The address of a write changes only after `ram_write_n` has returned to 1.
- R9: After a read, `ram_read_n` stays 1 for REL = max(1, ceil(T_OEZ_NS/period)) cycles, followed by at least one idle cycle, before `ram_dq_drive` can rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request |
| host_ready | output | 1 | Controller idle, able to take a request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| host_rdata | output | 16 | Read data, unselected lanes zero |
| host_rvalid | output | 1 | One-cycle read data valid pulse |
| ram_addr | output | 18 | RAM address bus |
| ram_sel_n | output | 1 | RAM chip select, active low |
| ram_read_n | output | 1 | RAM output enable, active low |
| ram_write_n | output | 1 | RAM write strobe, active low |
| ram_lane_n | output | 2 | RAM byte lane strobes, active low |
| ram_dq_out | output | 16 | Data toward RAM |
| ram_dq_drive | output | 1 | Enable for the external data driver |
| ram_dq_in | input | 16 | Data from RAM |

## Verification
The case that is hardest to reach from the ports is bus turnaround. That is a write request waiting at the exact cycle a read releases the bus, so the gap between the last cycle with the RAM output enabled and the first cycle with the host driver enabled is as short as it can be. The bench reaches it by raising the write request at the sample point where the read's ready returns. It then counts samples between the two events and compares the count with REL plus one. The bench timing parameters are overridden so that access and write pulse last several cycles, and the counted phase lengths are then distinguishable from the one-cycle default.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_RD_ACC   = 3'd1,
    PH_RD_REL   = 3'd2,
    PH_WR_LEAD  = 3'd3,
    PH_WR_PULSE = 3'd4,
    PH_WR_HOLD  = 3'd5
  } phase_t;

  // cycles covering a time in ns at a clock period in ps, rounded up
  function automatic int ns_to_cyc(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rd_acc_cycles(input int aa_ns, input int rc_ns, input int p_ps);
    return imax(1, imax(ns_to_cyc(aa_ns, p_ps), ns_to_cyc(rc_ns, p_ps)));
  endfunction

  function automatic int rel_cycles(input int oez_ns, input int p_ps);
    return imax(1, ns_to_cyc(oez_ns, p_ps));
  endfunction

  function automatic int lead_cycles(input int oeh_ns, input int p_ps);
    return imax(1, ns_to_cyc(oeh_ns, p_ps));
  endfunction

  function automatic int pulse_cycles(input int pwe_ns, input int ds_ns, input int aw_ns,
                                      input int wc_ns, input int lead, input int p_ps);
    int r;
    r = imax(1, ns_to_cyc(pwe_ns, p_ps));
    r = imax(r, ns_to_cyc(ds_ns, p_ps));
    r = imax(r, ns_to_cyc(aw_ns, p_ps) - lead);
    r = imax(r, ns_to_cyc(wc_ns, p_ps) - lead - 1);
    return r;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3 R5 a phase length of zero would collapse a timing minimum
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int LANES         = 2,
  parameter int T_AA_NS       = 10,
  parameter int T_RC_NS       = 10,
  parameter int T_OEZ_NS      = 4,
  parameter int T_OEH_NS      = 4,
  parameter int T_PWE_NS      = 8,
  parameter int T_DS_NS       = 6,
  parameter int T_AW_NS       = 8,
  parameter int T_WC_NS       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             is_write,
  input  logic [LANES-1:0] mask,
  output logic             ready,
  output logic             accept,
  output logic             capture,
  output logic             busy,
  output logic             sel_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [LANES-1:0] lane_n,
  output logic             dq_drive
);

  localparam int ACC   = rd_acc_cycles(T_AA_NS, T_RC_NS, CLK_PERIOD_PS);
  localparam int REL   = rel_cycles(T_OEZ_NS, CLK_PERIOD_PS);
  localparam int LEAD  = lead_cycles(T_OEH_NS, CLK_PERIOD_PS);
  localparam int PULSE = pulse_cycles(T_PWE_NS, T_DS_NS, T_AW_NS, T_WC_NS, LEAD, CLK_PERIOD_PS);
  localparam int MAXC  = imax(imax(ACC, REL), imax(LEAD, PULSE));
  localparam int CW    = $clog2(MAXC + 1);

  phase_t        phase, nxt;
  logic          tm_load, tm_expired;
  logic [CW-1:0] tm_val;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .expired  (tm_expired)
  );

  assign ready   = (phase == PH_IDLE);
  assign accept  = ready && req;
  assign capture = (phase == PH_RD_ACC) && tm_expired;
  assign busy    = !sel_n;

  always_comb begin
    nxt     = phase;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (phase)
      PH_IDLE: if (req) begin
        tm_load = 1'b1;
        if (is_write) begin nxt = PH_WR_LEAD; tm_val = CW'(LEAD); end
        else          begin nxt = PH_RD_ACC;  tm_val = CW'(ACC);  end
      end
      PH_RD_ACC: if (tm_expired) begin
        nxt = PH_RD_REL; tm_load = 1'b1; tm_val = CW'(REL);
      end
      PH_RD_REL:  if (tm_expired) nxt = PH_IDLE;
      PH_WR_LEAD: if (tm_expired) begin
        nxt = PH_WR_PULSE; tm_load = 1'b1; tm_val = CW'(PULSE);
      end
      PH_WR_PULSE: if (tm_expired) begin
        nxt = PH_WR_HOLD; tm_load = 1'b1; tm_val = CW'(1);
      end
      PH_WR_HOLD: if (tm_expired) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  // pins are registered from the next phase so they align with it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      sel_n    <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      dq_drive <= 1'b0;
      lane_n   <= '1;
    end else begin
      phase    <= nxt;
      sel_n    <= (nxt == PH_IDLE);
      rd_n     <= (nxt != PH_RD_ACC);
      wr_n     <= (nxt != PH_WR_PULSE);
      dq_drive <= (nxt == PH_WR_PULSE) || (nxt == PH_WR_HOLD);
      if (accept)              lane_n <= ~mask;
      else if (nxt == PH_IDLE) lane_n <= '1;
    end
  end

  // R6 output enable and write strobe are never low together
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> rd_n);

  // R7 host driver never fights an enabled RAM output
  drive_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> rd_n);

  // R7 data still driven in the cycle after the write strobe rises
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> dq_drive);

  // R2 ready only while the RAM is deselected
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sel_n && rd_n && wr_n));

  // R8 lane strobes stay put during an access
  lane_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && $past(!sel_n)) |-> $stable(lane_n));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              busy,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [LANES-1:0]  mask_in,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, lane_bits;
  logic [LANES-1:0]  mask_q;
  logic              rvalid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[g*LANE_W +: LANE_W] = {LANE_W{mask_q[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= addr_in;
        wdata_q <= wdata_in;
        mask_q  <= mask_in;
      end
      if (capture) rdata_q <= dq_in & lane_bits;
      rvalid_q <= capture;
    end
  end

  assign ram_addr = addr_q;
  assign dq_out   = wdata_q;
  assign rdata    = rdata_q;
  assign rvalid   = rvalid_q;

  // R8 address held for the whole access
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));

  // R3 read valid is a single-cycle pulse
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int ADDR_W        = 18,
  parameter int LANES         = 2,
  parameter int LANE_W        = 8,
  parameter int T_AA_NS       = 10,
  parameter int T_RC_NS       = 10,
  parameter int T_OEZ_NS      = 4,
  parameter int T_OEH_NS      = 4,
  parameter int T_PWE_NS      = 8,
  parameter int T_DS_NS       = 6,
  parameter int T_AW_NS       = 8,
  parameter int T_WC_NS       = 10,
  localparam int DATA_W       = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_mask,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_sel_n,
  output logic              ram_read_n,
  output logic              ram_write_n,
  output logic [LANES-1:0]  ram_lane_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_drive,
  input  logic [DATA_W-1:0] ram_dq_in
);

  logic accept, capture, busy;

  asram_seq #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS), .LANES (LANES),
    .T_AA_NS (T_AA_NS), .T_RC_NS (T_RC_NS), .T_OEZ_NS (T_OEZ_NS),
    .T_OEH_NS (T_OEH_NS), .T_PWE_NS (T_PWE_NS), .T_DS_NS (T_DS_NS),
    .T_AW_NS (T_AW_NS), .T_WC_NS (T_WC_NS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (host_req),
    .is_write (host_we),
    .mask     (host_mask),
    .ready    (host_ready),
    .accept   (accept),
    .capture  (capture),
    .busy     (busy),
    .sel_n    (ram_sel_n),
    .rd_n     (ram_read_n),
    .wr_n     (ram_write_n),
    .lane_n   (ram_lane_n),
    .dq_drive (ram_dq_drive)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .busy     (busy),
    .capture  (capture),
    .addr_in  (host_addr),
    .wdata_in (host_wdata),
    .mask_in  (host_mask),
    .dq_in    (ram_dq_in),
    .ram_addr (ram_addr),
    .dq_out   (ram_dq_out),
    .rdata    (host_rdata),
    .rvalid   (host_rvalid)
  );

endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

  localparam int P_PS = 10000;
  localparam int AA = 25, RC = 10, OEZ = 4, OEH = 4, PWE = 18, DS = 6, AW = 8, WC = 10;

  function automatic int cdiv(input int ns);
    int c;
    c = 0;
    while (c * P_PS < ns * 1000) c++;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int e_acc, e_rel, e_lead, e_pulse;
  int checks = 0, errors = 0;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  mask = '0;
  logic        ready, rvalid, sel_n, rd_n, wr_n, drive;
  logic [15:0] rdata, dq_out, dq_in;
  logic [17:0] r_addr;
  logic [1:0]  lane_n;
  logic [15:0] mem [0:255];

  always #5 clk = ~clk;

  asram_ctrl #(
    .CLK_PERIOD_PS (P_PS), .T_AA_NS (AA), .T_RC_NS (RC), .T_OEZ_NS (OEZ),
    .T_OEH_NS (OEH), .T_PWE_NS (PWE), .T_DS_NS (DS), .T_AW_NS (AW), .T_WC_NS (WC)
  ) i_asram_ctrl (
    .clk (clk), .rst_n (rst_n), .host_req (req), .host_ready (ready),
    .host_we (we), .host_addr (addr), .host_wdata (wdata), .host_mask (mask),
    .host_rdata (rdata), .host_rvalid (rvalid), .ram_addr (r_addr),
    .ram_sel_n (sel_n), .ram_read_n (rd_n), .ram_write_n (wr_n),
    .ram_lane_n (lane_n), .ram_dq_out (dq_out), .ram_dq_drive (drive),
    .ram_dq_in (dq_in)
  );

  // RAM model: lanes written at the end of the write strobe
  always @(posedge wr_n) begin
    if (sel_n === 1'b0) begin
      if (!lane_n[0]) mem[r_addr[7:0]][7:0]  = dq_out[7:0];
      if (!lane_n[1]) mem[r_addr[7:0]][15:8] = dq_out[15:8];
    end
  end
  always_comb begin
    if (!sel_n && !rd_n && wr_n)
      dq_in = {lane_n[1] ? 8'hA5 : mem[r_addr[7:0]][15:8],
               lane_n[0] ? 8'h5A : mem[r_addr[7:0]][7:0]};
    else
      dq_in = 16'hC3C3;
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // bus monitor sampled away from the edge
  logic        p_sel_n = 1, p_rd_n = 1, p_wr_n = 1;
  logic [17:0] p_addr = '0;
  int          since_rd = 100;
  always @(negedge clk) begin
    if (rst_n) begin
      if (drive) check(rd_n, "R7", "drive with output enabled", rd_n, 1);
      if (!sel_n && !p_sel_n && r_addr != p_addr)
        check(0, "R8", "address moved in access", r_addr, p_addr);
      if (!p_wr_n && r_addr != p_addr)
        check(0, "R8", "address moved before write end", r_addr, p_addr);
      if (drive && !p_rd_n) check(0, "R9", "no turnaround gap", 0, 1);
      if (drive && since_rd < 100) begin
        check(since_rd >= e_rel + 1, "R9", "turnaround gap", since_rd, e_rel + 1);
        since_rd = 100;
      end
      if (!rd_n) since_rd = 0;
      else if (since_rd < 100) since_rd++;
      p_sel_n = sel_n; p_rd_n = rd_n; p_wr_n = wr_n; p_addr = r_addr;
    end
  end

  task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    while (!ready) @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; mask = m;
    @(negedge clk);
    req = 0;
    check(!ready, "R2", "ready after accept", ready, 0);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int lead, pulse, drv;
    lead = 0; pulse = 0; drv = 0;
    issue(1, a, d, m);
    while (wr_n && !ready) begin
      if (!sel_n && rd_n) lead++;
      @(negedge clk);
    end
    check(lead == e_lead, "R6", "lead cycles", lead, e_lead);
    check(lane_n == ~m, "R4", "write lanes", lane_n, ~m);
    check(r_addr == a, "R8", "write address", r_addr, a);
    while (!wr_n) begin
      pulse++;
      if (drive) drv++;
      @(negedge clk);
    end
    check(pulse == e_pulse, "R5", "write pulse", pulse, e_pulse);
    check(drv == e_pulse && drive, "R7", "driver window", drv, e_pulse);
    while (!ready) begin
      check(!ready, "R2", "ready while busy", ready, 0);
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] m, input logic [15:0] exp);
    int k;
    k = 1;
    issue(0, a, 16'h0, m);
    check(!rd_n && !sel_n && wr_n && lane_n == ~m, "R3", "read pins", {rd_n, sel_n, wr_n}, 3'b001);
    while (!rvalid && k < 50) begin k++; @(negedge clk); end
    check(k == e_acc + 1, "R3", "read latency", k, e_acc + 1);
    check(rdata == exp, "R4", "read data", rdata, exp);
    @(negedge clk);
    check(!rvalid, "R3", "rvalid single pulse", rvalid, 0);
    while (!ready) @(negedge clk);
  endtask

  task automatic t_reset;
    check(ready && sel_n && rd_n && wr_n && lane_n == 2'b11 && !drive && !rvalid,
          "R1", "idle pins", {ready, sel_n, rd_n, wr_n, lane_n, drive, rvalid}, 8'b11111100);
  endtask

  task automatic t_full_word;
    do_write(18'h00010, 16'hBEEF, 2'b11);
    do_read(18'h00010, 2'b11, 16'hBEEF);
  endtask

  task automatic t_lanes;
    do_write(18'h00010, 16'h1234, 2'b10);
    do_read(18'h00010, 2'b11, 16'h12EF);
    do_read(18'h00010, 2'b01, 16'h00EF);
    do_read(18'h00010, 2'b10, 16'h1200);
    do_write(18'h00010, 16'hFFFF, 2'b00);
    do_read(18'h00010, 2'b11, 16'h12EF);
  endtask

  task automatic t_high_addr;
    do_write(18'h3FF80, 16'h55AA, 2'b11);
    do_read(18'h3FF80, 2'b11, 16'h55AA);
    check(r_addr == 18'h3FF80, "R8", "address held after access", r_addr, 18'h3FF80);
  endtask

  task automatic t_turnaround;
    do_read(18'h00020, 2'b11, 16'h0000);
    do_write(18'h00020, 16'hA1B2, 2'b01);
    do_read(18'h00020, 2'b11, 16'h00B2);
  endtask

  initial begin
    e_acc   = mx(1, mx(cdiv(AA), cdiv(RC)));
    e_rel   = mx(1, cdiv(OEZ));
    e_lead  = mx(1, cdiv(OEH));
    e_pulse = mx(mx(mx(1, cdiv(PWE)), cdiv(DS)), mx(cdiv(AW) - e_lead, cdiv(WC) - e_lead - 1));
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_full_word;
    t_lanes;
    t_high_addr;
    t_turnaround;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule